// File: doc/BRIEF.md
# Four-Channel Tick-Driven System Timer

This peripheral holds four independent up-counters, each advanced by its own tick-enable input, so that one channel can run from a 32768 Hz strobe, another from a 1 kHz strobe and two from 1 MHz strobes. The strobes are generated elsewhere in the chip. Each channel counts toward a programmable terminal count. It either wraps and keeps firing (continuous) or fires once and stops (one-shot). A pending flag, gated by a per-channel interrupt enable, drives one interrupt line per channel.

Software controls the block over a single-cycle read/write bus. Each channel owns a 64-byte window. Three offsets in that window are pure command strobes: a write of any value resets, starts or stops the channel. Other offsets hold the mode, the interrupt enable, the terminal count, an acknowledge port and two read-only views (a packed status word and the live count). One word above the channel windows holds a shared clock-request bit. The typical use is one channel in one-shot mode as an event timer and another in continuous mode with the largest terminal count as a free-running time base.

Top module: `qtt_top`

## Requirements
- R1: After reset every channel reads status 0x01 (idle, nothing set), count 0 and terminal count 0. All interrupt lines are low and the clock-request output is 0.
- R2: While a channel is enabled, its count rises by exactly one on each clock cycle in which its tick input is high. It holds in every other cycle.
- R3: On a tick where the count already equals the active terminal count, the channel sets pending and the count returns to 0, so one period is terminal count + 1 ticks.
- R4: Mode bit 0 = 0 (continuous) leaves the channel running after a terminal event. Mode bit 0 = 1 (one-shot) clears the enable, so the status state reads idle and the count stays at 0.
- R5: Status word: bits [3:0] give the state (1 = idle, 2 = running), bit 4 = enabled, bit 5 = programmed mode is one-shot, bit 6 = interrupt enabled, bit 7 = pending, and all other bits are 0.
- R6: The interrupt line equals pending AND interrupt-enable bit 0. A write to the acknowledge offset with bit 7 set clears pending. A write with bit 7 clear leaves it. If a terminal event falls in the acknowledge cycle, pending stays set.
- R7: Any write to offset 0x00 clears count and pending and disables the channel, and keeps the terminal count, mode and interrupt enable. Any write to 0x08 stops counting and keeps the count. Any write to 0x04 starts the channel. A command in the same cycle as a tick takes precedence over the tick.
- R8: A terminal count or mode written while the channel runs is applied only at the next restart: an enable from the disabled state, or a continuous wrap.
- R9: Channel n answers at base n*0x40. Its offsets are 0x00 reset, 0x04 enable, 0x08 disable, 0x0C mode, 0x10 status, 0x14 count, 0x18 terminal count (read/write), 0x1C interrupt enable and 0x20 acknowledge. Offset 0x100 is the clock-request register, bit 0 read/write, which drives the clock-request output.
- R10: Reads of command, mode, interrupt-enable and acknowledge offsets, of misaligned addresses and of unmapped words return 0. Writes to status and count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | N_CH | Per-channel count strobe |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | N_CH | Per-channel interrupt |
| clk_request | output | 1 | Shared clock-request bit |

## Verification
The hardest condition to reach is a terminal event that lands in the same cycle as an acknowledge write, together with the deferred reload of a terminal count rewritten mid-run. Both depend on a tick arriving in one exact cycle. The directed part of the bench drives the tick inputs itself. It steps a channel to one tick short of its terminal count, then raises the tick in the same cycle as the acknowledge or reprogramming write. A seeded random phase then mixes commands, small terminal counts, random tick patterns and reads, and compares each read and each interrupt line against a reference model kept in the bench.

// File: rtl/qtt_pkg.sv
package qtt_pkg;
  localparam int DATA_W   = 32;
  localparam int WIN_BITS = 6;   // 64-byte window per channel
  localparam int WORD_W   = 4;   // word index inside a window

  // word index = byte offset / 4
  localparam logic [WORD_W-1:0] OFS_RST  = 4'd0;
  localparam logic [WORD_W-1:0] OFS_ENA  = 4'd1;
  localparam logic [WORD_W-1:0] OFS_DIS  = 4'd2;
  localparam logic [WORD_W-1:0] OFS_MODE = 4'd3;
  localparam logic [WORD_W-1:0] OFS_STAT = 4'd4;
  localparam logic [WORD_W-1:0] OFS_CNT  = 4'd5;
  localparam logic [WORD_W-1:0] OFS_TC   = 4'd6;
  localparam logic [WORD_W-1:0] OFS_IE   = 4'd7;
  localparam logic [WORD_W-1:0] OFS_ACK  = 4'd8;

  localparam logic [3:0] ST_IDLE = 4'd1;
  localparam logic [3:0] ST_RUN  = 4'd2;
  localparam int ACK_BIT = 7;

  typedef struct packed {
    logic rst;
    logic ena;
    logic dis;
    logic mode;
    logic tc;
    logic ie;
    logic ack;
  } ch_wr_t;

  function automatic logic [DATA_W-1:0] pack_status(input logic en, input logic os,
                                                    input logic ie, input logic pd);
    return {{(DATA_W-8){1'b0}}, pd, ie, os, en, (en ? ST_RUN : ST_IDLE)};
  endfunction

  function automatic logic ack_hits(input logic [DATA_W-1:0] wdata);
    return wdata[ACK_BIT];
  endfunction
endpackage

// File: rtl/qtt_decode.sv
module qtt_decode
  import qtt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 9
) (
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  output logic [N_CH-1:0]          win_hit,
  output logic [WORD_W-1:0]        word_idx,
  output logic                     glob_hit,
  output ch_wr_t [N_CH-1:0]        wr_strb
);
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int GLOB_ADDR = N_CH << WIN_BITS;

  logic              aligned;
  logic              in_chan;
  logic [CH_W-1:0]   ch_idx;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_chan  = aligned && (bus_addr < ADDR_W'(GLOB_ADDR));
  assign ch_idx   = bus_addr[WIN_BITS +: CH_W];
  assign word_idx = bus_addr[2 +: WORD_W];
  assign glob_hit = bus_valid && (bus_addr == ADDR_W'(GLOB_ADDR));

  for (genvar i = 0; i < N_CH; i++) begin : g_win
    assign win_hit[i] = bus_valid && in_chan && (ch_idx == CH_W'(i));

    always_comb begin
      wr_strb[i] = '0;
      if (win_hit[i] && bus_write) begin
        unique case (word_idx)
          OFS_RST:  wr_strb[i].rst  = 1'b1;
          OFS_ENA:  wr_strb[i].ena  = 1'b1;
          OFS_DIS:  wr_strb[i].dis  = 1'b1;
          OFS_MODE: wr_strb[i].mode = 1'b1;
          OFS_TC:   wr_strb[i].tc   = 1'b1;
          OFS_IE:   wr_strb[i].ie   = 1'b1;
          OFS_ACK:  wr_strb[i].ack  = 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qtt_channel.sv
module qtt_channel
  import qtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  ch_wr_t             wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   tc_prog,
  output logic [DATA_W-1:0]  status,
  output logic               irq,
  output logic               evt,
  output logic               cmd,
  output logic               enabled,
  output logic               pending,
  output logic               live_os
);
  logic [CNT_W-1:0] cnt_q, tc_q, tc_live_q;
  logic             os_q, os_live_q, ie_q, en_q, pd_q;
  logic             hit;

  assign cmd = wr.rst | wr.ena | wr.dis;
  assign hit = (cnt_q == tc_live_q);
  assign evt = en_q & tick & hit & ~cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tc_q      <= '0;
      tc_live_q <= '0;
      os_q      <= 1'b0;
      os_live_q <= 1'b0;
      ie_q      <= 1'b0;
      en_q      <= 1'b0;
      pd_q      <= 1'b0;
    end else begin
      if (wr.tc)   tc_q <= wdata[CNT_W-1:0];
      if (wr.mode) os_q <= wdata[0];
      if (wr.ie)   ie_q <= wdata[0];
      if (wr.ack && ack_hits(wdata)) pd_q <= 1'b0;

      if (wr.rst) begin
        cnt_q <= '0;
        pd_q  <= 1'b0;
        en_q  <= 1'b0;
      end else if (wr.dis) begin
        en_q <= 1'b0;
      end else if (wr.ena) begin
        en_q <= 1'b1;
        if (!en_q) begin
          tc_live_q <= tc_q;
          os_live_q <= os_q;
        end
      end else if (en_q && tick) begin
        if (hit) begin
          pd_q  <= 1'b1;   // event wins over a same-cycle acknowledge
          cnt_q <= '0;
          if (os_live_q) begin
            en_q <= 1'b0;
          end else begin
            tc_live_q <= tc_q;
            os_live_q <= os_q;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count   = cnt_q;
  assign tc_prog = tc_q;
  assign status  = pack_status(en_q, os_q, ie_q, pd_q);
  assign irq     = pd_q & ie_q;
  assign enabled = en_q;
  assign pending = pd_q;
  assign live_os = os_live_q;
endmodule

// File: rtl/qtt_top.sv
module qtt_top
  import qtt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    tick_en,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [N_CH-1:0]    irq,
  output logic               clk_request
);
  logic [N_CH-1:0]              win_hit;
  logic [WORD_W-1:0]            word_idx;
  logic                         glob_hit;
  ch_wr_t [N_CH-1:0]            wr_strb;

  logic [N_CH-1:0]              ch_evt, ch_cmd, ch_rcmd, ch_en, ch_pd, ch_los;
  logic [N_CH-1:0][CNT_W-1:0]   ch_cnt, ch_tc;
  logic [N_CH-1:0][DATA_W-1:0]  ch_stat;
  logic                         crq_q;

  qtt_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .win_hit   (win_hit),
    .word_idx  (word_idx),
    .glob_hit  (glob_hit),
    .wr_strb   (wr_strb)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    qtt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en[i]),
      .wr      (wr_strb[i]),
      .wdata   (bus_wdata),
      .count   (ch_cnt[i]),
      .tc_prog (ch_tc[i]),
      .status  (ch_stat[i]),
      .irq     (irq[i]),
      .evt     (ch_evt[i]),
      .cmd     (ch_cmd[i]),
      .enabled (ch_en[i]),
      .pending (ch_pd[i]),
      .live_os (ch_los[i])
    );
    assign ch_rcmd[i] = wr_strb[i].rst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    crq_q <= 1'b0;
    else if (glob_hit && bus_write) crq_q <= bus_wdata[0];
  end
  assign clk_request = crq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (glob_hit) bus_rdata = {{(DATA_W-1){1'b0}}, crq_q};
      for (int i = 0; i < N_CH; i++) begin
        if (win_hit[i]) begin
          case (word_idx)
            OFS_STAT: bus_rdata = ch_stat[i];
            OFS_CNT:  bus_rdata = DATA_W'(ch_cnt[i]);
            OFS_TC:   bus_rdata = DATA_W'(ch_tc[i]);
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/qtt_checker.sv
module qtt_checker #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CH-1:0]         tick,
  input logic [N_CH-1:0]         evt,
  input logic [N_CH-1:0]         cmd,
  input logic [N_CH-1:0]         rcmd,
  input logic [N_CH-1:0]         en,
  input logic [N_CH-1:0]         pend,
  input logic [N_CH-1:0]         los,
  input logic [N_CH-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && tick[i] && !evt[i] && !cmd[i]) |=> (cnt[i] == $past(cnt[i]) + ONE)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !cmd[i]) |=> $stable(cnt[i])); // R2
    AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> (pend[i] && cnt[i] == '0)); // R3
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && los[i]) |=> !en[i]); // R4
    AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !los[i]) |=> en[i]); // R4
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      rcmd[i] |=> (cnt[i] == '0 && !pend[i] && !en[i])); // R7
  end
endmodule

bind qtt_top qtt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .tick (tick_en),
  .evt  (ch_evt),
  .cmd  (ch_cmd),
  .rcmd (ch_rcmd),
  .en   (ch_en),
  .pend (ch_pd),
  .los  (ch_los),
  .cnt  (ch_cnt)
);

// File: tb/qtt_top_test.sv
module qtt_top_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_en;
  logic        bv = 1'b0, bw = 1'b0;
  logic [8:0]  ba = '0;
  logic [31:0] bd = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        crq;

  always #(CLK_P/2) clk = ~clk;

  qtt_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bv), .bus_write(bw),
    .bus_addr(ba), .bus_wdata(bd), .bus_rdata(rdata), .irq(irq), .clk_request(crq)
  );

  int   total = 0, bad = 0;
  bit   rand_phase = 1'b0;
  logic [3:0] tick_force = 4'd0, tick_rnd = 4'd0;
  assign tick_en = rand_phase ? tick_rnd : tick_force;
  always @(negedge clk) tick_rnd <= 4'($urandom);

  // reference model built from the requirements
  logic [31:0] m_cnt[4], m_tc[4], m_tcl[4];
  bit m_os[4], m_osl[4], m_ie[4], m_en[4], m_pd[4];
  bit m_crq;

  function automatic logic [31:0] exp_stat(bit en, bit os, bit ie, bit pd);
    return (32'(pd) << 7) | (32'(ie) << 6) | (32'(os) << 5) | (32'(en) << 4) | (en ? 32'd2 : 32'd1);
  endfunction

  always @(posedge clk) begin : model
    logic wh;
    int   w;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] <= 0; m_tc[c] <= 0; m_tcl[c] <= 0;
        m_os[c] <= 0; m_osl[c] <= 0; m_ie[c] <= 0; m_en[c] <= 0; m_pd[c] <= 0;
      end
      m_crq <= 0;
    end else begin
      if (bv && bw && ba == 9'h100) m_crq <= bd[0];
      for (int c = 0; c < 4; c++) begin
        wh = bv && bw && ba < 9'h100 && ba[1:0] == 2'b00 && int'(ba[7:6]) == c;
        w  = int'(ba[5:2]);
        if (wh && w == 6) m_tc[c] <= bd;
        if (wh && w == 3) m_os[c] <= bd[0];
        if (wh && w == 7) m_ie[c] <= bd[0];
        if (wh && w == 8 && bd[7]) m_pd[c] <= 0;
        if (wh && w == 0) begin
          m_cnt[c] <= 0; m_pd[c] <= 0; m_en[c] <= 0;
        end else if (wh && w == 2) begin
          m_en[c] <= 0;
        end else if (wh && w == 1) begin
          m_en[c] <= 1;
          if (!m_en[c]) begin m_tcl[c] <= m_tc[c]; m_osl[c] <= m_os[c]; end
        end else if (m_en[c] && tick_en[c]) begin
          if (m_cnt[c] == m_tcl[c]) begin
            m_pd[c] <= 1; m_cnt[c] <= 0;
            if (m_osl[c]) m_en[c] <= 0;
            else begin m_tcl[c] <= m_tc[c]; m_osl[c] <= m_os[c]; end
          end else begin
            m_cnt[c] <= m_cnt[c] + 1;
          end
        end
      end
    end
  end

  function automatic logic [31:0] mread(logic [8:0] a);
    int c;
    if (a == 9'h100) return {31'd0, m_crq};
    if (a > 9'h0FF || a[1:0] != 2'b00) return 0;
    c = int'(a[7:6]);
    case (a[5:2])
      4'd4: return exp_stat(m_en[c], m_os[c], m_ie[c], m_pd[c]);
      4'd5: return m_cnt[c];
      4'd6: return m_tc[c];
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] mirq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = m_pd[c] & m_ie[c];
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bv = 1; bw = 1; ba = a; bd = d;
    @(negedge clk); bv = 0; bw = 0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bv = 1; bw = 0; ba = a;
    #1 chk(rdata, exp, tag);
    bv = 0;
  endtask

  task automatic rd_model(input logic [8:0] a, input string tag);
    @(negedge clk); bv = 1; bw = 0; ba = a;
    #1 chk(rdata, mread(a), tag);
    bv = 0;
  endtask

  task automatic irq_chk(input logic [3:0] exp, input string tag);
    @(negedge clk); #1 chk({28'd0, irq}, {28'd0, exp}, tag);
  endtask

  task automatic ticks(input logic [3:0] mask, input int n);
    @(negedge clk); tick_force = mask;
    repeat (n) @(negedge clk);
    tick_force = 0;
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(9'(c*64 + 16), 32'h01, "R1 status after reset");
      rd(9'(c*64 + 20), 32'h0, "R1 count after reset");
      rd(9'(c*64 + 24), 32'h0, "R1 tc after reset");
    end
    irq_chk(4'd0, "R1 irq after reset");
    chk({31'd0, crq}, 32'd0, "R1 clk_request after reset");

    // R9 clock request and tc read/write
    wr(9'h100, 32'h1);
    chk({31'd0, crq}, 32'd1, "R9 clk_request set");
    rd(9'h100, 32'h1, "R9 clk request readback");
    wr(9'h100, 32'h2);
    chk({31'd0, crq}, 32'd0, "R9 clk_request uses bit0");
    wr(9'h018, 32'hDEADBEEF);
    rd(9'h018, 32'hDEADBEEF, "R9 tc readback");
    wr(9'h018, 32'h0);

    // R10 write-only / unmapped reads, ignored writes
    wr(9'h014, 32'h5);
    wr(9'h010, 32'hFF);
    rd(9'h014, 32'h0, "R10 count write ignored");
    rd(9'h010, 32'h1, "R10 status write ignored");
    rd(9'h000, 0, "R10 read of reset cmd");
    rd(9'h004, 0, "R10 read of enable cmd");
    rd(9'h00C, 0, "R10 read of mode");
    rd(9'h01C, 0, "R10 read of irq enable");
    rd(9'h020, 0, "R10 read of ack");
    rd(9'h03C, 0, "R10 unmapped word");
    rd(9'h012, 0, "R10 misaligned");
    rd(9'h104, 0, "R10 above map");

    // channel 2 continuous, tc = 3
    wr(9'h098, 3); wr(9'h08C, 0); wr(9'h09C, 1); wr(9'h084, 0);
    rd(9'h090, 32'h52, "R5 running continuous status");
    ticks(4'b0100, 3);
    rd(9'h094, 3, "R2 count after three ticks");
    rd(9'h090, 32'h52, "R3 no event before terminal");
    ticks(4'b0100, 1);
    rd(9'h094, 0, "R3 count wraps");
    rd(9'h090, 32'hD2, "R3 pending set");
    irq_chk(4'b0100, "R6 irq raised");
    wr(9'h0A0, 32'h0);
    rd(9'h090, 32'hD2, "R6 ack without bit7 ignored");
    wr(9'h0A0, 32'h80);
    rd(9'h090, 32'h52, "R6 ack clears");
    irq_chk(4'd0, "R6 irq dropped");

    // R8 deferred terminal count
    wr(9'h098, 1);
    ticks(4'b0100, 2);
    rd(9'h094, 2, "R8 old tc still active");
    ticks(4'b0100, 2);
    rd(9'h094, 0, "R8 wrap on old tc");
    wr(9'h0A0, 32'h80);
    ticks(4'b0100, 2);
    rd(9'h090, 32'hD2, "R8 new tc after wrap");
    ticks(4'b0100, 1);
    rd(9'h094, 1, "R8 counting to new tc");

    // R7 disable / reset / enable
    wr(9'h088, 0);
    ticks(4'b0100, 3);
    rd(9'h094, 1, "R7 disable holds count");
    rd(9'h090, 32'hC1, "R7 disabled keeps pending");
    wr(9'h080, 0);
    rd(9'h090, 32'h41, "R7 reset clears pending and enable");
    rd(9'h094, 0, "R7 reset clears count");
    rd(9'h098, 1, "R7 reset keeps tc");
    wr(9'h084, 0);
    rd(9'h090, 32'h52, "R7 enable restarts, mode and ie kept");
    // command in the same cycle as a tick wins
    @(negedge clk); tick_force = 4'b0100; bv = 1; bw = 1; ba = 9'h088; bd = 0;
    @(negedge clk); tick_force = 0; bv = 0; bw = 0;
    rd(9'h094, 0, "R7 disable beats tick");
    wr(9'h080, 0);

    // R4 one-shot on channel 1
    wr(9'h058, 2); wr(9'h04C, 1); wr(9'h05C, 1); wr(9'h044, 0);
    rd(9'h050, 32'h72, "R5 running one-shot status");
    ticks(4'b0010, 3);
    rd(9'h050, 32'hE1, "R4 one-shot fires and idles");
    rd(9'h054, 0, "R4 count back at zero");
    ticks(4'b0010, 2);
    rd(9'h054, 0, "R4 stopped after one-shot");
    irq_chk(4'b0010, "R6 one-shot irq");
    wr(9'h060, 32'hFF);
    irq_chk(4'd0, "R6 ack any value with bit7");

    // R6 event and acknowledge in the same cycle (channel 3, tc = 0)
    wr(9'h0DC, 1); wr(9'h0C4, 0);
    ticks(4'b1000, 1);
    rd(9'h0D0, 32'hD2, "R3 tc zero fires each tick");
    @(negedge clk); tick_force = 4'b1000; bv = 1; bw = 1; ba = 9'h0E0; bd = 32'h80;
    @(negedge clk); tick_force = 0; bv = 0; bw = 0;
    rd(9'h0D0, 32'hD2, "R6 event wins over ack");
    wr(9'h0E0, 32'h80);
    rd(9'h0D0, 32'h52, "R6 plain ack after race");

    // random phase
    rand_phase = 1;
    for (int k = 0; k < 3000; k++) begin
      int c, w;
      logic [8:0] a;
      logic [31:0] d;
      c = $urandom_range(0, 3);
      w = $urandom_range(0, 9);
      a = (w == 9) ? 9'h100 : 9'(c*64 + w*4);
      d = (w == 6) ? 32'($urandom_range(0, 6)) : $urandom;
      if ($urandom_range(0, 2) == 0) wr(a, d);
      else rd_model(a, "R9 random read vs model");
      @(negedge clk); #1 chk({28'd0, irq}, {28'd0, mirq()}, "R6 random irq vs model");
    end
    rand_phase = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule